// File: doc/BRIEF.md
# Dual-Address Row Hit Scanner

This block empties one row of comparator hit flags at a time. A row arrives as a flat bit vector over a valid/ready handshake from the row buffer. At acceptance the vector can be widened so that the channels on either side of every hit are also read out, even when those channels fell below threshold. The scanner then walks the row by priority, lowest channel first. Each clock it presents up to two channel addresses, which steer two analog output multiplexers.

Each reported channel is removed from the pending set. No trigger input exists: scanning starts on the clock after a row is taken, and the buffer may offer the next row as soon as the current one is drained. At 128 channels, a row with n pending channels takes max(1, ceil(n/2)) cycles.

Top module: `hit_pair_scanner`

## Requirements
- R1: During reset and on the first cycle after it, `in_ready` is 1 and `slot0_vld`, `slot1_vld` and `row_done` are all 0.
- R2: A row is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge up to and including the row's `row_done` cycle, and it is 1 on the next cycle. A vector or `nbr_en` value offered while `in_ready` is 0 has no effect on the reports.
- R3: On the cycle right after a row is taken, either `slot0_vld` or `row_done` is 1. No trigger is needed.
- R4: `slot0_addr` is the lowest pending channel index. `slot1_addr` is the second-lowest. `slot1_vld` is 1 only when `slot0_vld` is 1 and `slot1_addr` > `slot0_addr`.
- R5: When exactly one channel is pending, `slot0_vld` is 1 and `slot1_vld` is 0.
- R6: Every reported channel is cleared in the same cycle. Each pending channel is reported exactly once, in ascending order over the row.
- R7: `row_done` is 1 only in the cycle that reports the last pending channels, so a row of n channels lasts ceil(n/2) cycles.
- R8: An all-zero row gives `row_done` on the first cycle after acceptance with no valid slot.
- R9: When `nbr_en` is 1 at acceptance, channel i is pending if bit i, i-1 or i+1 of `in_hits` is set. Channels 0 and NCH-1 have only one neighbour, and nothing wraps around.
- R10: When `nbr_en` is 0 at acceptance, the pending set equals `in_hits` bit for bit.
- R11: `nbr_en` is sampled only at acceptance. Changing it during a scan does not alter the row being scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Row buffer offers a row |
| in_ready | output | 1 | Scanner can take a row |
| in_hits | input | NCH | Hit flags, bit i = channel i |
| nbr_en | input | 1 | Mark neighbours of hits |
| slot0_vld | output | 1 | Slot 0 carries an address |
| slot0_addr | output | $clog2(NCH) | Lowest pending channel |
| slot1_vld | output | 1 | Slot 1 carries an address |
| slot1_addr | output | $clog2(NCH) | Second-lowest pending channel |
| row_done | output | 1 | Last reports of the row |

## Verification
A row taken on clock edge k produces its first pair of addresses and its done flag in the cycle that follows edge k, because only the pending register lies in between. Each later pair appears one cycle after the previous one, and `in_ready` rises one cycle after `row_done`. The bench drives inputs and samples outputs on the falling edge. It keeps its own pending set for the row and steps it once per falling edge, so every comparison lands in the cycle where the result is due. Random rows of varied density and neighbour setting are mixed with directed empty, single, edge-channel and full rows.

// File: rtl/scan_pkg.sv
// Package: shared constants and the scanner state encoding.
// Assumes: nothing; used by every scanner module.
package scan_pkg;
    localparam int unsigned SCAN_DEF_NCH = 128;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_BUSY = 1'b1
    } scan_state_e;
endpackage

// File: rtl/nbr_mark.sv
// Module: nbr_mark
// Widens a hit vector so that each hit's direct neighbours are also set
// when en is high. Edges do not wrap. Purely combinational.
// Assumes: NCH >= 2.
module nbr_mark #(
    parameter int unsigned NCH = scan_pkg::SCAN_DEF_NCH
) (
    input  logic           en,
    input  logic [NCH-1:0] hits_i,
    output logic [NCH-1:0] hits_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_bit
            if (gi == 0) begin : g_lo
                // lowest channel: only the upper neighbour exists
                assign hits_o[gi] = hits_i[gi] | (en & hits_i[gi+1]);
            end else if (gi == NCH-1) begin : g_hi
                // highest channel: only the lower neighbour exists
                assign hits_o[gi] = hits_i[gi] | (en & hits_i[gi-1]);
            end else begin : g_mid
                // inner channel: both neighbours
                assign hits_o[gi] = hits_i[gi] | (en & (hits_i[gi-1] | hits_i[gi+1]));
            end
        end
    endgenerate
endmodule

// File: rtl/first_one_find.sv
// Module: first_one_find
// Returns the index of the lowest set bit and whether any bit is set.
// Assumes: AW is wide enough to index NCH channels.
module first_one_find #(
    parameter int unsigned NCH = scan_pkg::SCAN_DEF_NCH,
    parameter int unsigned AW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] vec,
    output logic           found,
    output logic [AW-1:0]  idx
);
    // priority search: the last hit seen going downward is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH-1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end
endmodule

// File: rtl/pair_pick.sv
// Module: pair_pick
// Selects the two lowest set bits of a pending vector and returns the
// vector with both removed.
// Assumes: the caller registers rest_o; no state here.
module pair_pick #(
    parameter int unsigned NCH = scan_pkg::SCAN_DEF_NCH,
    parameter int unsigned AW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] pend_i,
    output logic           v0_o,
    output logic [AW-1:0]  a0_o,
    output logic           v1_o,
    output logic [AW-1:0]  a1_o,
    output logic [NCH-1:0] rest_o
);
    logic [NCH-1:0] after0;

    first_one_find #(.NCH(NCH), .AW(AW)) u_first (
        .vec   (pend_i),
        .found (v0_o),
        .idx   (a0_o)
    );

    // drop the first winner before the second search
    always_comb begin
        after0 = pend_i;
        if (v0_o) after0[a0_o] = 1'b0;
    end

    first_one_find #(.NCH(NCH), .AW(AW)) u_second (
        .vec   (after0),
        .found (v1_o),
        .idx   (a1_o)
    );

    // drop the second winner to form the next pending set
    always_comb begin
        rest_o = after0;
        if (v1_o) rest_o[a1_o] = 1'b0;
    end
endmodule

// File: rtl/hit_pair_scanner.sv
// Module: hit_pair_scanner (top)
// Takes one row of hit flags over valid/ready, optionally marks neighbours,
// then reports up to two pending channels per clock, lowest first, clearing
// them, and flags row_done on the cycle of the last report.
// Assumes: synchronous active-low reset; NCH >= 2.
module hit_pair_scanner #(
    parameter int unsigned NCH = scan_pkg::SCAN_DEF_NCH,
    localparam int unsigned AW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [NCH-1:0] in_hits,
    input  logic           nbr_en,
    output logic           slot0_vld,
    output logic [AW-1:0]  slot0_addr,
    output logic           slot1_vld,
    output logic [AW-1:0]  slot1_addr,
    output logic           row_done
);
    import scan_pkg::*;

    scan_state_e    state;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] marked;
    logic [NCH-1:0] rest;
    logic           v0, v1;
    logic [AW-1:0]  a0, a1;
    logic           busy;

    nbr_mark #(.NCH(NCH)) u_mark (
        .en     (nbr_en),
        .hits_i (in_hits),
        .hits_o (marked)
    );

    pair_pick #(.NCH(NCH), .AW(AW)) u_pick (
        .pend_i (pend),
        .v0_o   (v0),
        .a0_o   (a0),
        .v1_o   (v1),
        .a1_o   (a1),
        .rest_o (rest)
    );

    assign busy       = (state == SCAN_BUSY);
    assign in_ready   = !busy;
    assign slot0_vld  = busy & v0;
    assign slot1_vld  = busy & v1;
    assign slot0_addr = a0;
    assign slot1_addr = a1;
    assign row_done   = busy & ~|rest;

    // load a row when idle, otherwise retire the reported channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SCAN_IDLE;
            pend  <= '0;
        end else if (busy) begin
            pend <= rest;
            if (row_done) state <= SCAN_IDLE;
        end else if (in_valid) begin
            pend  <= marked;
            state <= SCAN_BUSY;
        end
    end

    // R4
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot1_vld |-> (slot0_vld && slot1_addr > slot0_addr));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!slot0_vld && !row_done));

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> in_ready);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (slot0_vld || row_done));

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_vld && !row_done) |=>
            (slot0_vld && slot0_addr > $past(slot1_vld ? slot1_addr : slot0_addr)));

    // R5
    single_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_vld && !slot1_vld) |-> row_done);
endmodule

// File: tb/sim_hit_pair_scanner.sv
`timescale 1ns/1ps
module sim_hit_pair_scanner;
    localparam int NCH = 128;
    localparam int AW  = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [NCH-1:0] in_hits = '0;
    logic           nbr_en = 1'b0;
    logic           slot0_vld, slot1_vld, row_done;
    logic [AW-1:0]  slot0_addr, slot1_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hit_pair_scanner #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hits(in_hits), .nbr_en(nbr_en),
        .slot0_vld(slot0_vld), .slot0_addr(slot0_addr),
        .slot1_vld(slot1_vld), .slot1_addr(slot1_addr),
        .row_done(row_done)
    );

    task automatic check(string req, string what, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] expand(logic [NCH-1:0] v, bit en);
        logic [NCH-1:0] r = v;
        if (en)
            for (int i = 0; i < NCH; i++) begin
                if (i > 0 && v[i-1]) r[i] = 1'b1;
                if (i < NCH-1 && v[i+1]) r[i] = 1'b1;
            end
        return r;
    endfunction

    function automatic int lowest(logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [NCH-1:0] rand_row(int density);
        logic [NCH-1:0] r;
        for (int w = 0; w < NCH/32; w++) begin
            logic [31:0] x = $urandom();
            for (int d = 0; d < density; d++) x &= $urandom();
            r[w*32 +: 32] = x;
        end
        return r;
    endfunction

    // send one row and follow it to its end; tag names the rule under test
    task automatic run_row(logic [NCH-1:0] hits, bit en, string tag, bit flip_en);
        logic [NCH-1:0] pend = expand(hits, en);
        int total = $countones(pend);
        int seen  = 0;
        int cyc   = 0;
        @(negedge clk);
        check("R2", "ready before row", in_ready == 1'b1, int'(in_ready), 1);
        in_valid = 1'b1; in_hits = hits; nbr_en = en;
        @(posedge clk);
        @(negedge clk);
        // keep offering garbage while busy: must be ignored (R2, R11)
        in_hits = rand_row(0);
        nbr_en  = flip_en ? ~en : 1'($urandom());
        check("R3", "report after take", (slot0_vld || row_done) == 1'b1, 0, 1);
        forever begin
            int e0 = lowest(pend);
            logic [NCH-1:0] p2 = pend;
            int e1;
            bit edone;
            if (e0 >= 0) p2[e0] = 1'b0;
            e1 = lowest(p2);
            if (e1 >= 0) p2[e1] = 1'b0;
            edone = (p2 == '0);
            cyc++;
            check("R2", "ready while busy", in_ready == 1'b0, int'(in_ready), 0);
            check(tag, "slot0 valid", slot0_vld == (e0 >= 0), int'(slot0_vld), int'(e0 >= 0));
            if (e0 >= 0)
                check(tag, "slot0 addr", int'(slot0_addr) == e0, int'(slot0_addr), e0);
            check((e0 >= 0 && e1 < 0) ? "R5" : tag, "slot1 valid",
                  slot1_vld == (e1 >= 0), int'(slot1_vld), int'(e1 >= 0));
            if (e1 >= 0)
                check(tag, "slot1 addr", int'(slot1_addr) == e1, int'(slot1_addr), e1);
            check(total == 0 ? "R8" : "R7", "row_done", row_done == edone,
                  int'(row_done), int'(edone));
            seen += int'(slot0_vld) + int'(slot1_vld);
            pend = p2;
            if (edone || cyc > NCH) break;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R7", "row length", cyc == ((total + 1) / 2 > 0 ? (total + 1) / 2 : 1),
              cyc, (total + 1) / 2 > 0 ? (total + 1) / 2 : 1);
        check("R6", "reports per row", seen == total, seen, total);
        @(negedge clk);
        check("R2", "ready after done", in_ready == 1'b1, int'(in_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", in_ready == 1'b1, int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready", in_ready == 1'b1, int'(in_ready), 1);
        check("R1", "slot0", slot0_vld == 1'b0, int'(slot0_vld), 0);
        check("R1", "slot1", slot1_vld == 1'b0, int'(slot1_vld), 0);
        check("R1", "done", row_done == 1'b0, int'(row_done), 0);

        run_row('0, 1'b0, "R8", 1'b0);
        run_row('0, 1'b1, "R8", 1'b0);
        run_row(NCH'(1) << 0, 1'b0, "R5", 1'b0);
        run_row(NCH'(1) << (NCH-1), 1'b0, "R5", 1'b0);
        run_row((NCH'(1) << 0) | (NCH'(1) << (NCH-1)), 1'b1, "R9", 1'b0);
        run_row(NCH'(1) << 40, 1'b1, "R9", 1'b0);
        run_row({(NCH/2){2'b01}}, 1'b1, "R9", 1'b0);
        run_row({(NCH/2){2'b01}}, 1'b0, "R10", 1'b0);
        run_row(NCH'(1) << 7, 1'b1, "R11", 1'b1);
        run_row(NCH'(5) << 20, 1'b0, "R11", 1'b1);
        run_row('1, 1'b0, "R4", 1'b0);
        for (int n = 0; n < 40; n++) begin
            bit en = 1'($urandom());
            run_row(rand_row(n % 4), en, en ? "R9" : "R4", 1'b0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule